// File: doc/BRIEF.md
# Medium-speed clock enable generator

This block paces the bus masters of a processor subsystem with clock-enable pulses derived from one system clock. There is no clock gating: the system clock keeps running, and each master advances only in cycles where its enable is high. A 3-bit rate field selects full-rate operation or a divided rate of 1/2, 1/4, 1/8, 1/16 or 1/32. The divided enable comes from a free-running 5-bit prescaler, so its pulses are evenly spaced.

The CPU has its own enable. The secondary bus masters (the transfer controllers) have a second one. An override bit lets a secondary master that raises a transfer request run at the full system rate while the CPU keeps its divided rate. Software writes an 8-bit control byte and reads it back. Rate-field codes 110 and 111 are reserved. When one of them is written, the block keeps the last valid rate and raises an error flag.

A request to enter a low-power mode (subactive or watch) is answered one cycle later. It is accepted only while the stored rate field is 000.

Top module: `msclk_en_gen`

## Requirements
- R1: With an active rate code of 000, `cpu_en` is high in every cycle.
- R2: Active rate codes 001, 010, 011, 100 and 101 make `cpu_en` a one-cycle pulse every 2, 4, 8, 16 and 32 cycles. A pulse falls in the cycle where the prescaler bits below the selected ratio are all ones.
- R3: Writing a byte whose bits 2:1 are both 1 (codes 110 or 111) leaves the active rate unchanged and holds `sel_err` high until a valid code is written.
- R4: After reset, `rd_data` is 8'h01 (rate code 001, override bit 3 clear), `sel_err` is low, and the prescaler starts at zero, so `cpu_en` is first high in the second cycle.
- R5: While bit 3 of the control byte is 0, `aux_en` equals `cpu_en` in every cycle, whatever `xfer_req` does.
- R6: While bit 3 is 1, `aux_en` is high in every cycle from the cycle after `xfer_req` is sampled high. `cpu_en` keeps its divided pattern.
- R7: After `xfer_req` falls, `aux_en` stays high up to and including the next divided pulse, and then follows `cpu_en` again.
- R8: A new valid rate code becomes active only in the cycle where the prescaler is 31. No gap between `cpu_en` pulses is ever shorter or longer than the old or the new period.
- R9: A one-cycle `lp_req` produces exactly one of `lp_ack` or `lp_nak` in the next cycle. It is `lp_ack` only if the stored rate field (bits 2:0) is 000.
- R10: Bits 7:4 of the control byte are stored and read back on `rd_data` and have no effect on the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte: [3] override, [2:0] rate code, [7:4] spare |
| rd_data | output | 8 | Stored control byte |
| xfer_req | input | 1 | Transfer request from a secondary bus master |
| lp_req | input | 1 | Low-power transition request pulse |
| cpu_en | output | 1 | CPU clock enable |
| aux_en | output | 1 | Secondary bus-master clock enable |
| sel_err | output | 1 | Reserved rate code is stored |
| lp_ack | output | 1 | Low-power request accepted |
| lp_nak | output | 1 | Low-power request refused |

## Verification
A wrong prescaler value or active rate shows on `cpu_en` within one divided period, at most 32 cycles, as a pulse in the wrong cycle or a gap of the wrong length. A stale override state shows on `aux_en` at the first cycle where it should differ from `cpu_en`. A rate change applied away from the prescaler wrap gives a short or long gap at the switch. For these reasons both enables are compared with an independent model in every cycle. The low-power responses are checked one cycle after each request against the field that software wrote.

// File: rtl/msclk_en_gen.sv
module msclk_en_gen #(
  parameter int PRE_W = 5,
  parameter int SEL_W = 3,
  parameter int REG_W = 8,
  parameter int OVR_BIT = 3,
  parameter logic [REG_W-1:0] RST_VAL = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             xfer_req,
  input  logic             lp_req,
  output logic             cpu_en,
  output logic             aux_en,
  output logic             sel_err,
  output logic             lp_ack,
  output logic             lp_nak
);
  localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

  logic [REG_W-1:0] reg_q;
  logic [PRE_W-1:0] pre_q;
  logic [SEL_W-1:0] act_sel;
  logic [PRE_W-1:0] mask;
  logic             fast_q;
  logic             ovr;
  logic             div_pulse;
  logic             field_bad;

  assign ovr       = reg_q[OVR_BIT];
  assign field_bad = &reg_q[SEL_W-1:SEL_W-2];
  assign mask      = ~(PRE_TOP << act_sel);
  assign div_pulse = (pre_q & mask) == mask;

  assign rd_data = reg_q;
  assign sel_err = field_bad;
  assign cpu_en  = div_pulse;
  assign aux_en  = div_pulse | (ovr & fast_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= RST_VAL;
      pre_q   <= '0;
      act_sel <= RST_VAL[SEL_W-1:0];
      fast_q  <= 1'b0;
      lp_ack  <= 1'b0;
      lp_nak  <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (pre_q == PRE_TOP && !field_bad)
        act_sel <= reg_q[SEL_W-1:0];
      if (wr_en)
        reg_q <= wr_data;
      fast_q <= ovr & (xfer_req | (fast_q & ~div_pulse));
      lp_ack <= lp_req & (reg_q[SEL_W-1:0] == '0);
      lp_nak <= lp_req & (reg_q[SEL_W-1:0] != '0);
    end
  end
endmodule

module msclk_en_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       xfer_req,
  input logic       lp_req,
  input logic       cpu_en,
  input logic       aux_en,
  input logic       sel_err,
  input logic       lp_ack,
  input logic       lp_nak,
  input logic [2:0] act_sel
);
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n) act_sel == 3'd0 |-> cpu_en); // R1
  AST_RSV_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_data[2] && wr_data[1]) |=> sel_err); // R3
  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) sel_err |=> $stable(act_sel)); // R3
  AST_SHARED_EN: assert property (@(posedge clk) disable iff (!rst_n) !rd_data[3] |-> aux_en == cpu_en); // R5
  AST_FAST_START: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[3] && xfer_req) |=> (aux_en || !rd_data[3])); // R6
  AST_AUX_COVERS: assert property (@(posedge clk) disable iff (!rst_n) cpu_en |-> aux_en); // R6
  AST_LP_ONE: assert property (@(posedge clk) disable iff (!rst_n) !(lp_ack && lp_nak)); // R9
  AST_LP_ANSWER: assert property (@(posedge clk) disable iff (!rst_n) lp_req |=> (lp_ack || lp_nak)); // R9
  AST_LP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !lp_req |=> !(lp_ack || lp_nak)); // R9
endmodule

bind msclk_en_gen msclk_en_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .xfer_req(xfer_req), .lp_req(lp_req), .cpu_en(cpu_en), .aux_en(aux_en),
  .sel_err(sel_err), .lp_ack(lp_ack), .lp_nak(lp_nak), .act_sel(act_sel)
);

// File: tb/msclk_en_gen_tb.sv
module msclk_en_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic xfer_req = 1'b0;
  logic lp_req = 1'b0;
  logic [7:0] rd_data;
  logic cpu_en, aux_en, sel_err, lp_ack, lp_nak;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_q[$];

  always #4 clk = ~clk;

  msclk_en_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .xfer_req(xfer_req), .lp_req(lp_req), .cpu_en(cpu_en), .aux_en(aux_en),
    .sel_err(sel_err), .lp_ack(lp_ack), .lp_nak(lp_nak)
  );

  // Reference model built from the requirements
  int m_pre, m_sel, m_fast;
  logic [7:0] m_reg;
  bit exp_cpu, exp_aux;

  always_comb begin
    exp_cpu = ((m_pre + 1) % (1 << m_sel)) == 0;
    exp_aux = exp_cpu || (m_reg[3] && m_fast != 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_sel <= 1; m_reg <= 8'h01; m_fast <= 0;
    end else begin
      m_pre <= (m_pre + 1) % 32;
      if (m_pre == 31 && !(m_reg[2] && m_reg[1])) m_sel <= int'(m_reg[2:0]);
      if (wr_en) m_reg <= wr_data;
      m_fast <= (m_reg[3] && (xfer_req || (m_fast != 0 && !exp_cpu))) ? 1 : 0;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: every-cycle enable comparison and scoreboard pops
  always @(negedge clk) begin
    if (rst_n) begin
      check(cpu_en == exp_cpu, "R2/R8", "cpu_en", cpu_en, exp_cpu);
      check(aux_en == exp_aux, "R5/R6/R7", "aux_en", aux_en, exp_aux);
      if (lp_ack || lp_nak) begin
        if (exp_q.size() == 0)
          check(0, "R9", "unexpected lp response", 1, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          check(lp_ack == e && lp_nak == !e, "R9", "lp_ack", lp_ack, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic lp_try();
    @(negedge clk);
    exp_q.push_back(m_reg[2:0] == 3'd0);
    lp_req = 1'b1;
    @(negedge clk); lp_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic gap(int exp, string req);
    int n = 0;
    do @(negedge clk); while (!cpu_en);
    do begin @(negedge clk); n++; end while (!cpu_en);
    check(n == exp, req, "cpu_en period", n, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(rd_data == 8'h01, "R4", "rd_data after reset", rd_data, 8'h01);
    check(sel_err == 1'b0, "R4", "sel_err after reset", sel_err, 0);
    check(cpu_en == 1'b0, "R4", "cpu_en first cycle", cpu_en, 0);
    @(negedge clk);
    check(cpu_en == 1'b1, "R4", "cpu_en second cycle", cpu_en, 1);
    gap(2, "R2");
    wr(8'h00); repeat (40) @(negedge clk);
    gap(1, "R1");
    for (int c = 2; c <= 5; c++) begin
      wr(8'(c)); repeat (70) @(negedge clk);
      gap(1 << c, "R2");
    end
    wr(8'h01); wr(8'h05); repeat (10) @(negedge clk);
    gap(32, "R8");
    repeat (40) @(negedge clk);
    gap(32, "R8");
    wr(8'h03); repeat (40) @(negedge clk);
    wr(8'h06); @(negedge clk);
    check(sel_err == 1'b1, "R3", "sel_err code 110", sel_err, 1);
    repeat (40) @(negedge clk);
    gap(8, "R3");
    wr(8'h07);
    check(sel_err == 1'b1, "R3", "sel_err code 111", sel_err, 1);
    repeat (40) @(negedge clk);
    gap(8, "R3");
    lp_try();
    wr(8'h02);
    check(sel_err == 1'b0, "R3", "sel_err cleared", sel_err, 0);
    wr(8'hA3);
    check(rd_data == 8'hA3, "R10", "rd_data readback", rd_data, 8'hA3);
    repeat (40) @(negedge clk);
    gap(8, "R10");
    xfer_req = 1'b1; repeat (20) @(negedge clk);
    check(aux_en == cpu_en, "R5", "aux_en without override", aux_en, cpu_en);
    xfer_req = 1'b0;
    wr(8'h0B); repeat (3) @(negedge clk);
    xfer_req = 1'b1; @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      check(aux_en == 1'b1, "R6", "aux_en full rate", aux_en, 1);
      @(negedge clk);
    end
    gap(8, "R6");
    xfer_req = 1'b0;
    repeat (20) @(negedge clk);
    check(aux_en == cpu_en, "R7", "aux_en after release", aux_en, cpu_en);
    lp_try();
    wr(8'h00); lp_try();
    wr(8'h04); lp_try();
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R9", "responses outstanding", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule